// File: doc/BRIEF.md
# LED Blink PWM with Shadowed Settings

This block drives one LED pin with a fixed-duty pulse waveform. A prescale counter divides a selected source by the programmed prescaler plus one. The source is either a slow tick strobe or every system clock. Each prescaled step advances an 8-bit PWM counter, so one output period spans 256 steps. The pin is high while the PWM counter is below the active duty value.

Software writes the prescaler and duty into holding registers. While the block is blinking, new values stay in the holding registers until software raises an update request. They are then copied into the active registers when the current PWM period ends. Outside blink mode, the active registers follow the holding registers, so values written there apply as soon as blinking starts. The source select has no shadow and acts on the very next clock. The two non-blink modes force the pin low or high.

Top module: `blink_pwm`

## Requirements
- R1: Source select `src_sel` = 0 advances the prescaler only on cycles with `slow_tick` high; `src_sel` = 1 advances it on every clock.
- R2: In blink mode, over any 256×(P+1) consecutive source steps, where P is the active prescaler, the pin is high for exactly D×(P+1) of them, where D is the active duty. The pin is high while the PWM count is below D.
- R3: A duty of 0 keeps the pin low throughout blink mode. A duty of 255 makes it high for 255 of every 256 PWM counts.
- R4: In blink mode, writes to prescaler or duty do not change the waveform until an update request is made and the current PWM period then ends.
- R5: In blink mode, `upd_req` sets `upd_pending`. The flag clears on the period-end step that loads the holding values, which comes at most one full period after the request.
- R6: Changing `src_sel` during blink mode changes the output rate from the next clock, with no wait for a period end or an update request.
- R7: Mode encoding is 2'b00 = off, 2'b01 = blink, 2'b1x = on. Off holds the pin low and on holds it high, whatever the prescaler, duty or source settings.
- R8: Synchronous `soft_rst` clears both counters, the active prescaler and duty, and `upd_pending`. The holding registers are not cleared.
- R9: Outside blink mode, holding values go to the active registers directly, and `upd_req` is ignored, so `upd_pending` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| mode | input | 2 | 00 off, 01 blink, 1x on |
| src_sel | input | 1 | 0 slow tick, 1 system clock |
| slow_tick | input | 1 | One-cycle strobe from the slow source |
| presc_wr | input | 1 | Write strobe for the prescaler holding register |
| presc_in | input | 16 | Prescaler value |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_in | input | 8 | Duty value |
| upd_req | input | 1 | Request to load the holding values at the next period end |
| upd_pending | output | 1 | An update is waiting for a period end |
| led | output | 1 | LED drive |

## Verification
A wrong active duty shows up in the first complete period as a high-time count off by a multiple of P+1. A wrong prescaler count, or a wrong source enable, changes the number of pin transitions in a fixed window within one period. A shadow that loads too early changes the waveform before `upd_pending` is set. One that never loads leaves `upd_pending` stuck high beyond one period, or keeps the old high time after the flag falls. All of these become visible at the ports within one or two output periods.

// File: rtl/blink_pwm.sv
module blink_pwm #(
  parameter int PRESC_W = 16,
  parameter int DUTY_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [1:0]         mode,
  input  logic               src_sel,
  input  logic               slow_tick,
  input  logic               presc_wr,
  input  logic [PRESC_W-1:0] presc_in,
  input  logic               duty_wr,
  input  logic [DUTY_W-1:0]  duty_in,
  input  logic               upd_req,
  output logic               upd_pending,
  output logic               led
);
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic [PRESC_W-1:0] hold_presc, act_presc, pre_cnt;
  logic [DUTY_W-1:0]  hold_duty, act_duty, pwm_cnt;
  logic blinking, src_en, step, period_end;

  assign blinking   = (mode == 2'b01);
  assign src_en     = src_sel ? 1'b1 : slow_tick;
  assign step       = blinking && src_en && (pre_cnt == act_presc);
  assign period_end = step && (pwm_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_presc <= '0;
      hold_duty  <= '0;
    end else begin
      if (presc_wr) hold_presc <= presc_in;
      if (duty_wr)  hold_duty  <= duty_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_presc   <= '0;
      act_duty    <= '0;
      upd_pending <= 1'b0;
    end else if (soft_rst) begin
      act_presc   <= '0;
      act_duty    <= '0;
      upd_pending <= 1'b0;
    end else if (!blinking) begin
      act_presc   <= hold_presc;
      act_duty    <= hold_duty;
      upd_pending <= 1'b0;
    end else begin
      if (upd_pending && period_end) begin
        act_presc <= hold_presc;
        act_duty  <= hold_duty;
      end
      if (upd_req)         upd_pending <= 1'b1;
      else if (period_end) upd_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pwm_cnt <= '0;
    end else if (soft_rst || !blinking) begin
      pre_cnt <= '0;
      pwm_cnt <= '0;
    end else if (src_en) begin
      if (pre_cnt == act_presc) begin
        pre_cnt <= '0;
        pwm_cnt <= pwm_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign led = mode[1] ? 1'b1 : (blinking && (pwm_cnt < act_duty));

  a_r1_hold_without_source: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && !src_sel && !slow_tick && !soft_rst) |=> ($stable(pre_cnt) && $stable(pwm_cnt)));

  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= act_presc);

  a_r4_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && !soft_rst && !(upd_pending && period_end)) |=> ($stable(act_duty) && $stable(act_presc)));

  a_r5_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (blinking && upd_pending && period_end && !upd_req && !soft_rst) |=> !upd_pending);

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!upd_pending && pwm_cnt == '0 && pre_cnt == '0 && act_duty == '0));

  a_r9_no_pending_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!blinking) |=> (!upd_pending || blinking));
endmodule

// File: tb/sim_blink_pwm.sv
module sim_blink_pwm;
  logic clk = 0, rst_n = 0, soft_rst = 0, src_sel = 1, slow_tick = 0;
  logic [1:0] mode = 2'b00;
  logic presc_wr = 0, duty_wr = 0, upd_req = 0;
  logic [15:0] presc_in = '0;
  logic [7:0] duty_in = '0;
  logic upd_pending, led;
  int vecs = 0, bad = 0;
  logic tick_on = 0;
  int tc = 0;

  always #2.5 clk = ~clk;

  blink_pwm u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode(mode),
    .src_sel(src_sel), .slow_tick(slow_tick), .presc_wr(presc_wr), .presc_in(presc_in),
    .duty_wr(duty_wr), .duty_in(duty_in), .upd_req(upd_req),
    .upd_pending(upd_pending), .led(led));

  always @(negedge clk) begin
    slow_tick <= tick_on && (tc % 4 == 3);
    tc <= tc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic win(input int n, output int hi, output int edges);
    logic prev;
    hi = 0; edges = 0;
    @(negedge clk); prev = led; if (led) hi++;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (led) hi++;
      if (led != prev) edges++;
      prev = led;
    end
  endtask

  task automatic wr(input int p, input int d);
    @(negedge clk);
    presc_in = p[15:0]; duty_in = d[7:0]; presc_wr = 1; duty_wr = 1;
    @(negedge clk);
    presc_wr = 0; duty_wr = 0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_req = 1;
    @(negedge clk); upd_req = 0;
  endtask

  task automatic wait_pend(output int waited);
    waited = 0;
    while (upd_pending && waited < 2000) begin @(negedge clk); waited++; end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int hi, ed, w;
    int duties[9] = '{0, 1, 2, 7, 64, 128, 200, 254, 255};
    repeat (3) @(negedge clk);
    chk("R7 reset led", int'(led), 0);
    chk("R5 reset pending", int'(upd_pending), 0);
    rst_n = 1;

    // R2 R3 R9: sweep prescaler and duty, programmed outside blink
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 9; k++) begin
        @(negedge clk); mode = 2'b00;
        wr(p, duties[k]);
        @(negedge clk); mode = 2'b01;
        win(256 * (p + 1), hi, ed);
        chk($sformatf("R2 R3 R9 p=%0d d=%0d", p, duties[k]), hi, duties[k] * (p + 1));
      end

    // R9: update request ignored outside blink
    @(negedge clk); mode = 2'b00;
    pulse_upd();
    chk("R9 pending outside blink", int'(upd_pending), 0);

    // R7: forced levels
    wr(0, 0); @(negedge clk); mode = 2'b10;
    win(300, hi, ed); chk("R7 on high", hi, 300);
    @(negedge clk); mode = 2'b11;
    win(50, hi, ed); chk("R7 on alt code high", hi, 50);
    wr(0, 255); @(negedge clk); mode = 2'b00;
    win(300, hi, ed); chk("R7 off low", hi, 0);

    // R4 R5: shadowing of duty then prescaler
    wr(0, 64); @(negedge clk); mode = 2'b01;
    wr(0, 192);
    repeat (300) @(negedge clk);
    win(256, hi, ed); chk("R4 duty shadowed", hi, 64);
    chk("R5 no pending before request", int'(upd_pending), 0);
    pulse_upd();
    chk("R5 pending set", int'(upd_pending), 1);
    wait_pend(w);
    chk("R5 cleared within a period", int'(w <= 257), 1);
    win(256, hi, ed); chk("R4 duty loaded", hi, 192);
    wr(1, 192);
    repeat (300) @(negedge clk);
    win(256, hi, ed); chk("R4 prescaler shadowed", hi, 192);
    pulse_upd(); wait_pend(w);
    chk("R5 cleared within a period p=1", int'(w <= 513), 1);
    win(512, hi, ed); chk("R4 prescaler loaded", hi, 384);

    // R1 R6: source select acts at once
    @(negedge clk); mode = 2'b00; wr(0, 64);
    @(negedge clk); mode = 2'b01;
    win(1024, hi, ed); chk("R1 fast edges", ed, 8);
    @(negedge clk); src_sel = 0; tick_on = 0;
    win(600, hi, ed); chk("R6 frozen without tick", ed, 0);
    @(negedge clk); tick_on = 1;
    win(1024, hi, ed);
    chk("R1 slow edges", ed, 2);
    chk("R1 slow high time", hi, 256);
    @(negedge clk); src_sel = 1; tick_on = 0;
    win(1024, hi, ed); chk("R6 back to fast", ed, 8);

    // R8: soft reset
    wr(0, 128); pulse_upd();
    chk("R8 pending before soft reset", int'(upd_pending), 1);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk("R8 pending cleared", int'(upd_pending), 0);
    win(512, hi, ed); chk("R8 active duty cleared", hi, 0);
    @(negedge clk); mode = 2'b00;
    @(negedge clk); mode = 2'b01;
    win(256, hi, ed); chk("R8 holding kept", hi, 128);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule